// File: doc/BRIEF.md
# Interrupt Controller with Write-One-to-Clear Flags

This block collects single-cycle event pulses from fourteen on-chip sources and turns them into one level-sensitive interrupt request to the CPU. The sources are the display (vertical blank, horizontal blank, line-count match), four timers, the serial port, four DMA channels, the keypad and the cartridge slot. Each pulse sets a pending flag. The flag stays set until software clears it. Any per-peripheral sender enables are applied upstream, so each event input arrives already gated.

Software reaches three registers on a 16-bit peripheral bus. The source-enable mask is at byte offset 0x200, the pending flags are at 0x202 and the master-enable bit is at 0x208. Software clears a flag by writing a 1 to that flag's position. The request line is high only when the master enable is set and at least one pending flag is also enabled. The request is registered, so it follows the register state with one cycle of delay.

Top module: `irq_hub`

## Requirements
- R1: After reset (active-low, asynchronous) the enable, flag and master-enable registers read 0 and `irq_o` is 0.
- R2: A 1 on `evt_i[k]` at a clock edge sets flag bit k at that edge. The bit map is: bit 0 vertical blank, bit 1 horizontal blank, bit 2 line-count match, bits 3..6 timers 0..3, bit 7 serial, bits 8..11 DMA 0..3, bit 12 keypad, bit 13 cartridge.
- R3: A write to offset 0x202 clears every flag bit whose data bit is 1. Flag bits whose data bit is 0 keep their value.
- R4: When an event and a write-1 clear hit the same flag bit in the same cycle, the flag ends up set.
- R5: Flags latch whether or not the matching enable bit is set. Enabling a source later exposes an event that is already pending.
- R6: `irq_o` is registered. One clock edge after the registers change, it equals master AND (OR over k of enable[k] AND flag[k]).
- R7: Only data bit 0 of a write to offset 0x208 is stored as the master enable. A read of 0x208 returns it in bit 0 with the other bits 0. While the master enable is 0, `irq_o` stays 0.
- R8: A write to offset 0x200 stores data bits 13..0 as the enable mask. Reads of 0x200 and 0x202 return bits 15 and 14 as 0.
- R9: A write to any other offset changes no register, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 12 | Byte offset from the I/O base |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| evt_i | input | 14 | Event pulses, one bit per source |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
The hardest case to bring about is the race between an event and a write-1 clear on the same bit. It only shows up when both arrive at the same clock edge. The stimulus table drives a clear of the cartridge flag in the same vector that pulses the cartridge event, and then reads the flag back. The table also pulses events while their enables are off, and enables them afterwards. Together these show that pending state survives masking and that the registered request appears exactly one edge after the flag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_SRC = 14;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_W  = 12;

  localparam logic [ADDR_W-1:0] OFS_EN     = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_FLAG   = 12'h202;
  localparam logic [ADDR_W-1:0] OFS_MASTER = 12'h208;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_EN,
    RD_FLAG,
    RD_MASTER
  } rd_sel_e;

  typedef struct packed {
    logic en;
    logic flag;
    logic master;
  } wr_sel_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  output wr_sel_t       wr_o,
  output rd_sel_e       rd_o
);
  always_comb begin
    wr_o = '0;
    rd_o = RD_NONE;
    unique case (addr_i)
      OFS_EN:     begin rd_o = RD_EN;     wr_o.en     = we_i; end
      OFS_FLAG:   begin rd_o = RD_FLAG;   wr_o.flag   = we_i; end
      OFS_MASTER: begin rd_o = RD_MASTER; wr_o.master = we_i; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int unsigned N = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flag_q <= 1'b0;
      else if (evt_i[g])                  flag_q <= 1'b1;  // set beats clear
      else if (clr_we_i && clr_mask_i[g]) flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    // R2 R4 R5
    evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_o[g]);
    // R3
    clr_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_mask_i[g] && !evt_i[g]) |=> !flag_o[g]);
    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[g] && !(clr_we_i && clr_mask_i[g])) |=> $stable(flag_o[g]));
  end
endmodule

// File: rtl/irqc_request.sv
module irqc_request #(
  parameter int unsigned N = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] flag_i,
  input  logic         master_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= master_i & (|(en_i & flag_i));
  end
  assign irq_o = irq_q;

  // R7
  master_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> !irq_o);
  // R6
  pend_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && (en_i & flag_i) != '0) |=> irq_o);
  // R6
  none_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_i & flag_i) == '0) |=> !irq_o);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irqc_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_we_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [N-1:0]  evt_i,
  output logic          irq_o
);
  localparam int unsigned PAD_W = DW - N;

  wr_sel_t      wr_sel;
  rd_sel_e      rd_sel;
  logic [N-1:0] en_q;
  logic         master_q;
  logic [N-1:0] flag;

  irqc_decode #(.AW(AW)) i_decode (
    .addr_i (bus_addr_i),
    .we_i   (bus_we_i),
    .wr_o   (wr_sel),
    .rd_o   (rd_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      if (wr_sel.en)     en_q     <= bus_wdata_i[N-1:0];
      if (wr_sel.master) master_q <= bus_wdata_i[0];
    end
  end

  irqc_flags #(.N(N)) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .clr_we_i   (wr_sel.flag),
    .clr_mask_i (bus_wdata_i[N-1:0]),
    .flag_o     (flag)
  );

  irqc_request #(.N(N)) i_request (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .flag_i   (flag),
    .master_i (master_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (rd_sel)
      RD_EN:     bus_rdata_o = {{PAD_W{1'b0}}, en_q};
      RD_FLAG:   bus_rdata_o = {{PAD_W{1'b0}}, flag};
      RD_MASTER: bus_rdata_o = {{(DW-1){1'b0}}, master_q};
      default:   bus_rdata_o = '0;
    endcase
  end

  // R8
  rd_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DW-1:N] == '0);
  // R9
  stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i != OFS_EN && bus_addr_i != OFS_MASTER)
      |=> ($stable(en_q) && $stable(master_q)));
  // R8
  en_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_EN) |=> en_q == $past(bus_wdata_i[N-1:0]));
endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [13:0] evt = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_hub i_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  // {we, addr, wdata, evt, raddr, exp_rdata, exp_irq}
  localparam int NV = 16;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 12'h200, 16'hFFFF, 14'h0000, 12'h200, 16'h3FFF, 1'b0}, // R8
    {1'b0, 12'h000, 16'h0000, 14'h0001, 12'h202, 16'h0001, 1'b0}, // R2 R7
    {1'b1, 12'h208, 16'h0001, 14'h0000, 12'h208, 16'h0001, 1'b1}, // R6
    {1'b1, 12'h202, 16'h0001, 14'h0000, 12'h202, 16'h0000, 1'b0}, // R3
    {1'b1, 12'h200, 16'h0000, 14'h2000, 12'h202, 16'h2000, 1'b0}, // R5
    {1'b1, 12'h200, 16'h2000, 14'h0000, 12'h202, 16'h2000, 1'b1}, // R5
    {1'b1, 12'h202, 16'h1FFF, 14'h0000, 12'h202, 16'h2000, 1'b1}, // R3
    {1'b1, 12'h202, 16'h2000, 14'h2000, 12'h202, 16'h2000, 1'b1}, // R4
    {1'b1, 12'h202, 16'hFFFF, 14'h0000, 12'h202, 16'h0000, 1'b0}, // R3
    {1'b0, 12'h000, 16'h0000, 14'h1FF8, 12'h202, 16'h1FF8, 1'b0}, // R5
    {1'b1, 12'h208, 16'hFFFE, 14'h0000, 12'h208, 16'h0000, 1'b0}, // R7
    {1'b1, 12'h200, 16'h0008, 14'h0000, 12'h200, 16'h0008, 1'b0}, // R7
    {1'b1, 12'h208, 16'h0001, 14'h0000, 12'h208, 16'h0001, 1'b1}, // R6
    {1'b1, 12'h204, 16'hFFFF, 14'h0000, 12'h204, 16'h0000, 1'b1}, // R9
    {1'b0, 12'h000, 16'h0000, 14'h0000, 12'h202, 16'h1FF8, 1'b1}, // R9
    {1'b1, 12'h202, 16'h0008, 14'h0000, 12'h202, 16'h1FF0, 1'b0}  // R3 R6
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [15:0] d,
                      input logic [13:0] e);
    @(negedge clk);
    we = w; addr = a; wdata = d; evt = e;
    @(negedge clk);
    we = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [11:0] a);
    addr = a;
    #0.5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(12'h200); chk("R1 en", rdata, 16'h0);
    rd(12'h202); chk("R1 flag", rdata, 16'h0);
    rd(12'h208); chk("R1 master", rdata, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][71], VEC[i][70:59], VEC[i][58:43], VEC[i][42:29]);
      rd(VEC[i][28:17]);
      @(negedge clk);
      #0.5;
      chk($sformatf("vec%0d rdata", i), rdata, VEC[i][16:1]);
      chk($sformatf("vec%0d irq", i), {15'b0, irq}, {15'b0, VEC[i][0]});
    end

    // R6 latency: enabled timer 0 event -> flag now, request one edge later
    step(1'b0, 12'h202, 16'h0, 14'h0008);
    #0.5;
    chk("R6 irq before", {15'b0, irq}, 16'h0);
    rd(12'h202); chk("R2 timer0 flag", rdata, 16'h1FF8);
    @(negedge clk); #0.5;
    chk("R6 irq after", {15'b0, irq}, 16'h1);

    // R1 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #0.5;
    rd(12'h200); chk("R1 en again", rdata, 16'h0);
    rd(12'h202); chk("R1 flag again", rdata, 16'h0);
    rd(12'h208); chk("R1 master again", rdata, 16'h0);
    chk("R1 irq again", {15'b0, irq}, 16'h0);
    finish_run();
  end
endmodule